// File: doc/BRIEF.md
# PCIe MSI Capture Controller

This block sits beside the inbound path of a PCIe root complex and watches every memory write that arrives from the link. A write is a message-signalled interrupt when three things hold. Capture must be switched on. The write address must equal the programmed 64-bit target, with the two byte-offset bits ignored. The 16-bit write data must match a programmed pattern on every bit that a programmed compare mask selects. For such a write, the low data bits name one of the interrupt vectors. The status bit of that vector is set and stays set until the host acknowledges it.

A per-vector mask gates the status into one combined level interrupt towards the host. The host programs the block through a small word-indexed register port with eight slots:

| Slot | Access | Use |
|---|---|---|
| 0 | read/write | target address low word; bit 0 is the capture enable |
| 1 | read/write | target address high word |
| 2 | read/write | match word: compare mask in bits 31:16, expected pattern in bits 15:0 |
| 3 | read only | pending status |
| 4 | write only | acknowledge; write 1 to clear |
| 5 | read only | mask |
| 6 | write only | mask set |
| 7 | write only | mask clear |

A typical setup writes 0xFFE06540 to slot 2. An endpoint then raises vector n by writing 0x6540 OR n to the target.

Top module: `msi_capture`

## Requirements
- R1: After reset the pending status is all zero, the mask is all ones, both target words and the match word read zero (so capture is disabled), and irq_out is low.
- R2: With capture enabled, a write whose address bits 63:2 equal the target and whose data agrees with the pattern (match word bits 15:0) on every bit set in the compare mask (match word bits 31:16) sets the pending bit numbered by data bits 4:0. This holds for every one of the 32 vectors.
- R3: A write whose address bits 63:2 differ from the target sets no pending bit.
- R4: A write whose data differs from the pattern on any compared bit sets no pending bit.
- R5: While the enable (bit 0 of slot 0) is 0, no write sets a pending bit, and msg_hit stays low.
- R6: Writing slot 4 clears each pending bit whose data bit is 1; pending bits whose data bit is 0 are unchanged.
- R7: Pending bits are sticky, and several vectors may be pending at once. Slot 3 returns all of them together.
- R8: When a matching write for vector n and an acknowledge of bit n arrive in the same cycle, bit n ends up set.
- R9: Slot 6 sets and slot 7 clears mask bits for each 1 in the data. Writing all ones to slot 7 unmasks every vector. Slot 5 returns the mask.
- R10: irq_out is high exactly when some pending bit has its mask bit clear. It follows the state in the same cycle.
- R11: msg_hit is high, in the same cycle as msg_valid, for a write that meets every condition of R2, and is low otherwise.
- R12: Slots 0, 1 and 2 read back the last value written to them. Slots 4, 6 and 7 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low asynchronous reset |
| msg_valid | input | 1 | an inbound memory write is presented this cycle |
| msg_addr | input | 64 | byte address of the inbound write |
| msg_data | input | 16 | low 16 data bits of the inbound write |
| msg_hit | output | 1 | the presented write is claimed as an interrupt message |
| reg_we | input | 1 | register write strobe |
| reg_idx | input | 3 | register slot |
| reg_wdata | input | 32 | register write data |
| reg_rdata | output | 32 | register read data for the slot on reg_idx |
| irq_out | output | 1 | combined level interrupt to the host |

## Verification
The bench builds the block with its defaults: 32 vectors and an unregistered interrupt output. This lets a single sweep raise, observe and acknowledge every vector, with expected status words computed as one shifted bit. It can also check irq_out in the same cycle as the status change. Near misses are built arithmetically from the programmed target and pattern: an address one word off, an address with one high bit flipped, and data with one compared bit flipped. These show that the decode rejects each of them. The set-versus-acknowledge collision is driven on the same edge, once on the same vector and once on different vectors.

// File: rtl/msi_capture_pkg.sv
package msi_capture_pkg;
   localparam int REG_W = 32;
   localparam int TGT_W = 2 * REG_W;
   localparam int MSG_W = 16;
   localparam int IDX_W = 3;

   typedef enum logic [IDX_W-1:0] {
      RI_TGT_LO = 3'd0,
      RI_TGT_HI = 3'd1,
      RI_MATCH  = 3'd2,
      RI_PEND   = 3'd3,
      RI_ACK    = 3'd4,
      RI_MASK   = 3'd5,
      RI_MSET   = 3'd6,
      RI_MCLR   = 3'd7
   } reg_idx_e;
endpackage

// File: rtl/msi_cfg_regs.sv
module msi_cfg_regs
   import msi_capture_pkg::*;
#(
   parameter int NUM_VEC = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               reg_we,
   input  logic [IDX_W-1:0]   reg_idx,
   input  logic [REG_W-1:0]   reg_wdata,
   input  logic [NUM_VEC-1:0] pend,
   input  logic [NUM_VEC-1:0] mask,
   output logic [REG_W-1:0]   reg_rdata,
   output logic [TGT_W-1:0]   tgt,
   output logic               en,
   output logic [MSG_W-1:0]   cmp_mask,
   output logic [MSG_W-1:0]   cmp_pat,
   output logic [NUM_VEC-1:0] ack_v,
   output logic [NUM_VEC-1:0] mset_v,
   output logic [NUM_VEC-1:0] mclr_v
);
   logic [REG_W-1:0] tgt_lo_q, tgt_hi_q, match_q;
   logic [REG_W-1:0] pend_ext, mask_ext;
   reg_idx_e         idx;

   assign idx = reg_idx_e'(reg_idx);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tgt_lo_q <= '0;
         tgt_hi_q <= '0;
         match_q  <= '0;
      end else if (reg_we) begin
         case (idx)
            RI_TGT_LO: tgt_lo_q <= reg_wdata;
            RI_TGT_HI: tgt_hi_q <= reg_wdata;
            RI_MATCH:  match_q  <= reg_wdata;
            default:   ;
         endcase
      end
   end

   assign tgt      = {tgt_hi_q, tgt_lo_q};
   assign en       = tgt_lo_q[0];
   assign cmp_mask = match_q[REG_W-1:MSG_W];
   assign cmp_pat  = match_q[MSG_W-1:0];

   assign ack_v  = (reg_we && idx == RI_ACK)  ? reg_wdata[NUM_VEC-1:0] : '0;
   assign mset_v = (reg_we && idx == RI_MSET) ? reg_wdata[NUM_VEC-1:0] : '0;
   assign mclr_v = (reg_we && idx == RI_MCLR) ? reg_wdata[NUM_VEC-1:0] : '0;

   always_comb begin
      pend_ext = '0;
      mask_ext = '0;
      pend_ext[NUM_VEC-1:0] = pend;
      mask_ext[NUM_VEC-1:0] = mask;
   end

   always_comb begin
      case (idx)
         RI_TGT_LO: reg_rdata = tgt_lo_q;
         RI_TGT_HI: reg_rdata = tgt_hi_q;
         RI_MATCH:  reg_rdata = match_q;
         RI_PEND:   reg_rdata = pend_ext;
         RI_MASK:   reg_rdata = mask_ext;
         default:   reg_rdata = '0;
      endcase
   end
endmodule

// File: rtl/msi_match.sv
module msi_match
   import msi_capture_pkg::*;
#(
   parameter int NUM_VEC = 32
) (
   input  logic               msg_valid,
   input  logic [TGT_W-1:0]   msg_addr,
   input  logic [MSG_W-1:0]   msg_data,
   input  logic               en,
   input  logic [TGT_W-1:0]   tgt,
   input  logic [MSG_W-1:0]   cmp_mask,
   input  logic [MSG_W-1:0]   cmp_pat,
   output logic               hit,
   output logic [NUM_VEC-1:0] set_v
);
   localparam int VEC_W = $clog2(NUM_VEC);

   logic addr_eq, data_eq;
   logic unused_low_bits;

   assign addr_eq = (msg_addr[TGT_W-1:2] == tgt[TGT_W-1:2]);
   assign data_eq = (((msg_data ^ cmp_pat) & cmp_mask) == '0);
   assign hit     = msg_valid & en & addr_eq & data_eq;

   assign set_v = hit ? ({{(NUM_VEC-1){1'b0}}, 1'b1} << msg_data[VEC_W-1:0]) : '0;

   assign unused_low_bits = ^{msg_addr[1:0], tgt[1:0]};
endmodule

// File: rtl/msi_vec_bank.sv
module msi_vec_bank #(
   parameter int NUM_VEC = 32,
   parameter bit IRQ_REG = 1'b0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_VEC-1:0] set_v,
   input  logic [NUM_VEC-1:0] ack_v,
   input  logic [NUM_VEC-1:0] mset_v,
   input  logic [NUM_VEC-1:0] mclr_v,
   output logic [NUM_VEC-1:0] pend,
   output logic [NUM_VEC-1:0] mask,
   output logic               irq
);
   for (genvar v = 0; v < NUM_VEC; v++) begin : g_vec
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            pend[v] <= 1'b0;
            mask[v] <= 1'b1;
         end else begin
            // a new event beats an acknowledge of the same bit
            pend[v] <= (pend[v] & ~ack_v[v]) | set_v[v];
            // an unmask beats a mask of the same bit
            mask[v] <= (mask[v] | mset_v[v]) & ~mclr_v[v];
         end
      end
   end

   logic any_live;
   assign any_live = |(pend & ~mask);

   if (IRQ_REG) begin : g_irq_reg
      logic irq_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq_q <= 1'b0;
         else        irq_q <= any_live;
      end
      assign irq = irq_q;
   end else begin : g_irq_comb
      assign irq = any_live;
   end
endmodule

// File: rtl/msi_capture.sv
module msi_capture
   import msi_capture_pkg::*;
#(
   parameter int NUM_VEC = 32,
   parameter bit IRQ_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              msg_valid,
   input  logic [TGT_W-1:0]  msg_addr,
   input  logic [MSG_W-1:0]  msg_data,
   output logic              msg_hit,
   input  logic              reg_we,
   input  logic [IDX_W-1:0]  reg_idx,
   input  logic [REG_W-1:0]  reg_wdata,
   output logic [REG_W-1:0]  reg_rdata,
   output logic              irq_out
);
   if (NUM_VEC < 2 || NUM_VEC > REG_W || (NUM_VEC & (NUM_VEC - 1)) != 0) begin : g_bad_num_vec
      $error("NUM_VEC must be a power of two between 2 and the register width");
   end
   if ($clog2(NUM_VEC) > MSG_W) begin : g_bad_msg_w
      $error("vector index does not fit in the message data");
   end

   logic [TGT_W-1:0]   tgt;
   logic               en;
   logic [MSG_W-1:0]   cmp_mask, cmp_pat;
   logic [NUM_VEC-1:0] set_v, ack_v, mset_v, mclr_v;
   logic [NUM_VEC-1:0] status_q, mask_q;

   msi_cfg_regs #(.NUM_VEC(NUM_VEC)) u_regs (
      .clk(clk), .rst_n(rst_n),
      .reg_we(reg_we), .reg_idx(reg_idx), .reg_wdata(reg_wdata),
      .pend(status_q), .mask(mask_q), .reg_rdata(reg_rdata),
      .tgt(tgt), .en(en), .cmp_mask(cmp_mask), .cmp_pat(cmp_pat),
      .ack_v(ack_v), .mset_v(mset_v), .mclr_v(mclr_v)
   );

   msi_match #(.NUM_VEC(NUM_VEC)) u_match (
      .msg_valid(msg_valid), .msg_addr(msg_addr), .msg_data(msg_data),
      .en(en), .tgt(tgt), .cmp_mask(cmp_mask), .cmp_pat(cmp_pat),
      .hit(msg_hit), .set_v(set_v)
   );

   msi_vec_bank #(.NUM_VEC(NUM_VEC), .IRQ_REG(IRQ_REG)) u_bank (
      .clk(clk), .rst_n(rst_n),
      .set_v(set_v), .ack_v(ack_v), .mset_v(mset_v), .mclr_v(mclr_v),
      .pend(status_q), .mask(mask_q), .irq(irq_out)
   );
endmodule

// File: rtl/msi_capture_chk.sv
module msi_capture_chk #(
   parameter int NUM_VEC = 32
) (
   input logic               clk,
   input logic               rst_n,
   input logic               en,
   input logic               msg_hit,
   input logic [NUM_VEC-1:0] set_v,
   input logic [NUM_VEC-1:0] ack_v,
   input logic [NUM_VEC-1:0] mclr_v,
   input logic [NUM_VEC-1:0] status_q,
   input logic [NUM_VEC-1:0] mask_q
);
   // R5
   disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en |-> !msg_hit);

   // R2
   onehot_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(set_v));

   // R8
   set_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (set_v != '0) |=> ((status_q & $past(set_v)) == $past(set_v)));

   // R7
   sticky_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((status_q & $past(status_q & ~ack_v)) == $past(status_q & ~ack_v)));

   // R9
   unmask_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (&mclr_v) |=> (mask_q == '0));
endmodule

bind msi_capture msi_capture_chk #(.NUM_VEC(NUM_VEC)) u_chk (
   .clk(clk), .rst_n(rst_n), .en(en), .msg_hit(msg_hit),
   .set_v(set_v), .ack_v(ack_v), .mclr_v(mclr_v),
   .status_q(status_q), .mask_q(mask_q)
);

// File: tb/test_msi_capture.sv
module test_msi_capture;
   localparam int CLK_PERIOD = 10;
   localparam logic [63:0] TGT = 64'h0000_0000_FFFF_FFFC;
   localparam logic [15:0] PAT = 16'h6540;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        msg_valid = 1'b0;
   logic [63:0] msg_addr = '0;
   logic [15:0] msg_data = '0;
   logic        msg_hit;
   logic        reg_we = 1'b0;
   logic [2:0]  reg_idx = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        irq_out;

   int compared = 0;
   int mismatched = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   msi_capture i_msi_capture (
      .clk(clk), .rst_n(rst_n),
      .msg_valid(msg_valid), .msg_addr(msg_addr), .msg_data(msg_data), .msg_hit(msg_hit),
      .reg_we(reg_we), .reg_idx(reg_idx), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .irq_out(irq_out)
   );

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      compared++;
      if (act !== exp) begin
         mismatched++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic reg_wr(input logic [2:0] i, input logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_idx = i; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic reg_rd(input logic [2:0] i, output logic [31:0] d);
      reg_idx = i;
      #1;
      d = reg_rdata;
   endtask

   task automatic send(input logic [63:0] a, input logic [15:0] d, output logic hit);
      @(negedge clk);
      msg_valid = 1'b1; msg_addr = a; msg_data = d;
      #1 hit = msg_hit;
      @(negedge clk);
      msg_valid = 1'b0;
   endtask

   initial begin
      logic [31:0] rd;
      logic        h;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      reg_rd(3'd3, rd); chk("R1 pend", rd, 0);
      reg_rd(3'd5, rd); chk("R1 mask", rd, 32'hFFFF_FFFF);
      reg_rd(3'd0, rd); chk("R1 tgt_lo", rd, 0);
      reg_rd(3'd2, rd); chk("R1 match", rd, 0);
      chk("R1 irq", irq_out, 0);

      // R5 disabled: nothing captured before setup
      send(TGT, PAT, h); chk("R5 hit off", h, 0);
      reg_rd(3'd3, rd); chk("R5 pend off", rd, 0);

      reg_wr(3'd0, TGT[31:0] | 32'h1);
      reg_wr(3'd1, TGT[63:32]);
      reg_wr(3'd2, 32'hFFE0_6540);
      // R12 readback
      reg_rd(3'd0, rd); chk("R12 tgt_lo", rd, TGT[31:0] | 32'h1);
      reg_rd(3'd1, rd); chk("R12 tgt_hi", rd, TGT[63:32]);
      reg_rd(3'd2, rd); chk("R12 match", rd, 32'hFFE0_6540);
      reg_rd(3'd4, rd); chk("R12 ack reads 0", rd, 0);

      // R9 unmask all
      reg_wr(3'd7, 32'hFFFF_FFFF);
      reg_rd(3'd5, rd); chk("R9 unmask all", rd, 0);

      // R2 R11 R10 R6: every vector
      for (int n = 0; n < 32; n++) begin
         send(TGT, PAT | 16'(n), h);
         chk("R11 hit", h, 1);
         reg_rd(3'd3, rd); chk("R2 vector set", rd, 32'h1 << n);
         chk("R10 irq on", irq_out, 1);
         reg_wr(3'd4, 32'h1 << n);
         reg_rd(3'd3, rd); chk("R6 acked", rd, 0);
         chk("R10 irq off", irq_out, 0);
      end

      // R3 address misses
      send(TGT + 64'd4, PAT | 16'd3, h); chk("R3 hit word off", h, 0);
      send(TGT ^ (64'h1 << 40), PAT | 16'd3, h); chk("R3 hit high bit", h, 0);
      reg_rd(3'd3, rd); chk("R3 pend", rd, 0);

      // R4 data misses
      send(TGT, PAT ^ 16'h0020, h); chk("R4 hit bit5", h, 0);
      send(TGT, PAT ^ 16'h8000, h); chk("R4 hit bit15", h, 0);
      reg_rd(3'd3, rd); chk("R4 pend", rd, 0);
      chk("R4 irq", irq_out, 0);

      // R7 several pending
      send(TGT, PAT | 16'd3, h);
      send(TGT, PAT | 16'd7, h);
      send(TGT, PAT | 16'd31, h);
      reg_rd(3'd3, rd); chk("R7 multi pend", rd, 32'h8000_0088);
      // R6 zero bits untouched
      reg_wr(3'd4, 32'h0000_0080);
      reg_rd(3'd3, rd); chk("R6 partial ack", rd, 32'h8000_0008);
      reg_wr(3'd4, 32'hFFFF_FFFF);
      reg_rd(3'd3, rd); chk("R6 ack all", rd, 0);

      // R8 set and ack same cycle, same vector
      send(TGT, PAT | 16'd5, h);
      @(negedge clk);
      msg_valid = 1'b1; msg_addr = TGT; msg_data = PAT | 16'd5;
      reg_we = 1'b1; reg_idx = 3'd4; reg_wdata = 32'h20;
      @(negedge clk);
      msg_valid = 1'b0; reg_we = 1'b0;
      reg_rd(3'd3, rd); chk("R8 set wins", rd, 32'h20);
      // R8 different vectors in same cycle
      @(negedge clk);
      msg_valid = 1'b1; msg_addr = TGT; msg_data = PAT | 16'd6;
      reg_we = 1'b1; reg_idx = 3'd4; reg_wdata = 32'h20;
      @(negedge clk);
      msg_valid = 1'b0; reg_we = 1'b0;
      reg_rd(3'd3, rd); chk("R8 other vector", rd, 32'h40);
      reg_wr(3'd4, 32'hFFFF_FFFF);

      // R9 R10 masking
      reg_wr(3'd6, 32'h200);
      reg_rd(3'd5, rd); chk("R9 mask set", rd, 32'h200);
      send(TGT, PAT | 16'd9, h);
      reg_rd(3'd3, rd); chk("R10 masked pend", rd, 32'h200);
      chk("R10 masked irq", irq_out, 0);
      reg_wr(3'd7, 32'h200);
      reg_rd(3'd5, rd); chk("R9 mask clr", rd, 0);
      chk("R10 unmasked irq", irq_out, 1);
      reg_wr(3'd4, 32'h200);

      // R5 disable again
      reg_wr(3'd0, TGT[31:0]);
      send(TGT, PAT | 16'd1, h); chk("R5 hit disabled", h, 0);
      reg_rd(3'd3, rd); chk("R5 pend disabled", rd, 0);

      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         compared++;
         mismatched++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end
endmodule